// File: doc/BRIEF.md
# IR Carrier Burst Timer

This block shapes the waveform sent to an infrared emitter. A 10-bit timer word is loaded through a strobe: the low nine bits set a burst length in machine cycles, and the top bit decides whether the burst is modulated with a carrier or is a silent gap. A machine cycle is eight oscillator clocks. While a burst is live and the run control is high, the counter steps down once per machine cycle. When it expires, a done flag rises so that the controlling sequencer can load the next mark or space.

The carrier comes from a free-running divider. It runs at the oscillator rate divided by 8 or by 12. At divide-by-12 the duty is selectable between one half and one third. Because the divider is never restarted, loading a new word in the expiry cycle joins two marks with no glitch on the output. An active-low busy line follows the carrier gating. It can drive a transmit indicator.

Top module: `irb_burst_timer`

## Requirements
- R1: While rst_ni is low and after its release, rem_o is 0, busy_no is 1, done_o is 1, and all ten timer bits are clear.
- R2: A machine-cycle tick occurs on the 8th rising clock edge after reset release and on every 8th edge after that. On a tick with run_i high the live count decrements by one. With run_i low the count is frozen, and rem_o is 0 and busy_no is 1.
- R3: A word with count N loaded on a tick edge, with run_i high throughout, keeps busy_no low (enable bit 1) for exactly (N+1)*8 clocks. done_o is 0 from the load edge until the tick edge on which a zero count expires, and 1 after it.
- R4: load_data_i bit 9 is the carrier enable and bits 8:0 are the count. With bit 9 at 0 the burst is timed identically but rem_o stays 0 and busy_no stays 1.
- R5: busy_no is 0 exactly when a burst is live, run_i is 1 and the enable bit is 1. rem_o is 1 only when busy_no is 0.
- R6: A carrier phase counter starts at 0 on reset release and advances every clock. With car_sel_i = 0 it wraps after 7, and the carrier is high at phases 0 to 3 (fosc/8, 1/2 duty).
- R7: With car_sel_i = 1 the phase wraps after 11. The carrier is high at phases 0 to 5 when duty_sel_i = 0, and at phases 0 to 3 when duty_sel_i = 1. A phase at or beyond the wrap point goes to 0 on the next clock.
- R8: A load taken on the same edge as the expiring tick keeps the burst live with no cycle of done_o high or busy_no high, and the carrier phase is unaffected.
- R9: A load during a live burst replaces the count and the enable at once, and takes priority over a coincident decrement.
- R10: Loads never restart the carrier phase, so rem_o during a burst equals the carrier level of the free-running phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Timer run (1) or stop (0) |
| car_sel_i | input | 1 | Carrier divide: 0 = by 8, 1 = by 12 |
| duty_sel_i | input | 1 | Duty at divide-by-12: 0 = 1/2, 1 = 1/3 |
| load_i | input | 1 | Load strobe for the timer word |
| load_data_i | input | 10 | Bit 9 carrier enable, bits 8:0 count |
| rem_o | output | 1 | Modulated emitter drive |
| busy_no | output | 1 | Low while the carrier is driven |
| done_o | output | 1 | High when no burst is live |

## Verification
The bench uses the default parameters: a 9-bit count, an 8-clock machine cycle, and carrier divides of 8 and 12. With these, a full-scale burst of 512 machine cycles fits easily in the run, so the largest count is exercised next to short random bursts. Keeping the real divide ratios makes both duty settings and the wrap on a change of divide reachable within a few dozen clocks. Loads placed by the bench on the expiring tick cover seamless reloading, and random loads in mid-burst cover load priority over decrement.

// File: rtl/irb_pkg.sv
package irb_pkg;
  typedef enum logic {
    CAR_DIV_LO = 1'b0,
    CAR_DIV_HI = 1'b1
  } car_sel_e;

  typedef enum logic {
    DUTY_HALF  = 1'b0,
    DUTY_THIRD = 1'b1
  } duty_sel_e;

  // high-phase length for a divider setting
  function automatic int unsigned car_high_len(input int unsigned div_lo,
                                               input int unsigned div_hi,
                                               input logic sel,
                                               input logic duty);
    if (sel == CAR_DIV_LO) return div_lo / 2;
    if (duty == DUTY_THIRD) return div_hi / 3;
    return div_hi / 2;
  endfunction
endpackage

// File: rtl/irb_cycle_gen.sv
module irb_cycle_gen #(
  parameter int unsigned CYC_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  assign tick_o = (pre_q == LAST);
endmodule

// File: rtl/irb_carrier_gen.sv
module irb_carrier_gen
  import irb_pkg::*;
#(
  parameter int unsigned DIV_LO = 8,
  parameter int unsigned DIV_HI = 12,
  localparam int unsigned DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO,
  localparam int unsigned PH_W = $clog2(DIV_MAX)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic            duty_i,
  output logic            car_o,
  output logic [PH_W-1:0] ph_o
);
  localparam logic [PH_W-1:0] LAST_LO = PH_W'(DIV_LO - 1);
  localparam logic [PH_W-1:0] LAST_HI = PH_W'(DIV_HI - 1);
  localparam logic [PH_W-1:0] HI_LO   = PH_W'(car_high_len(DIV_LO, DIV_HI, CAR_DIV_LO, DUTY_HALF));
  localparam logic [PH_W-1:0] HI_HALF = PH_W'(car_high_len(DIV_LO, DIV_HI, CAR_DIV_HI, DUTY_HALF));
  localparam logic [PH_W-1:0] HI_3RD  = PH_W'(car_high_len(DIV_LO, DIV_HI, CAR_DIV_HI, DUTY_THIRD));

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] last;
  logic [PH_W-1:0] high_len;

  always_comb begin
    last     = (sel_i == CAR_DIV_HI) ? LAST_HI : LAST_LO;
    high_len = HI_LO;
    if (sel_i == CAR_DIV_HI) high_len = (duty_i == DUTY_THIRD) ? HI_3RD : HI_HALF;
  end

  // free running; a divide change past the wrap point folds back to 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else if (ph_q >= last) ph_q <= '0;
    else ph_q <= ph_q + 1'b1;
  end

  assign car_o = (ph_q < high_len);
  assign ph_o  = ph_q;
endmodule

// File: rtl/irb_down_counter.sv
module irb_down_counter #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W:0]   load_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o,
  output logic             live_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      en_q   <= 1'b0;
      live_q <= 1'b0;
    end else if (load_i) begin
      // load wins over a coincident tick: seamless reload
      cnt_q  <= load_data_i[CNT_W-1:0];
      en_q   <= load_data_i[CNT_W];
      live_q <= 1'b1;
    end else if (run_i && tick_i && live_q) begin
      if (cnt_q == '0) live_q <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign en_o   = en_q;
  assign live_o = live_q;
endmodule

// File: rtl/irb_burst_timer.sv
module irb_burst_timer #(
  parameter int unsigned CNT_W   = 9,
  parameter int unsigned CYC_DIV = 8,
  parameter int unsigned DIV_LO  = 8,
  parameter int unsigned DIV_HI  = 12,
  localparam int unsigned DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO,
  localparam int unsigned PH_W    = $clog2(DIV_MAX)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           car_sel_i,
  input  logic           duty_sel_i,
  input  logic           load_i,
  input  logic [CNT_W:0] load_data_i,
  output logic           rem_o,
  output logic           busy_no,
  output logic           done_o
);
  logic             tick;
  logic             car;
  logic [PH_W-1:0]  car_ph;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             live_q;
  logic             gate;

  generate
    if (CYC_DIV < 2 || DIV_LO < 2 || DIV_HI < 3) begin : g_bad_cfg
      initial $error("irb_burst_timer: divider parameters too small");
    end
  endgenerate

  irb_cycle_gen #(.CYC_DIV(CYC_DIV)) u_cyc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  irb_carrier_gen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_car (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (car_sel_i),
    .duty_i(duty_sel_i),
    .car_o (car),
    .ph_o  (car_ph)
  );

  irb_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .tick_i     (tick),
    .load_i     (load_i),
    .load_data_i(load_data_i),
    .cnt_o      (cnt_q),
    .en_o       (en_q),
    .live_o     (live_q)
  );

  assign gate    = live_q & run_i & en_q;
  assign rem_o   = gate & car;
  assign busy_no = ~gate;
  assign done_o  = ~live_q;
endmodule

// File: rtl/irb_burst_checker.sv
module irb_burst_checker #(
  parameter int unsigned CNT_W  = 9,
  parameter int unsigned PH_W   = 4,
  parameter int unsigned DIV_HI = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             load_i,
  input logic             rem_o,
  input logic             busy_no,
  input logic             done_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic [PH_W-1:0]  ph_i
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(DIV_HI - 1);

  p_rem_in_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_o |-> !busy_no);

  p_done_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_no && !rem_o));

  p_step_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ((cnt_i == $past(cnt_i)) || (cnt_i == ($past(cnt_i) - ONE))));

  p_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_i));

  p_phase_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_i <= PH_LAST);

  p_reload_live_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !done_o);
endmodule

bind irb_burst_timer irb_burst_checker #(
  .CNT_W (CNT_W),
  .PH_W  (PH_W),
  .DIV_HI(DIV_MAX)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .run_i  (run_i),
  .load_i (load_i),
  .rem_o  (rem_o),
  .busy_no(busy_no),
  .done_o (done_o),
  .cnt_i  (cnt_q),
  .ph_i   (car_ph)
);

// File: tb/sim_irb_burst_timer.sv
module sim_irb_burst_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic       car_sel_i = 1'b0;
  logic       duty_sel_i = 1'b0;
  logic       load_i = 1'b0;
  logic [9:0] load_data_i = '0;
  logic       rem_o, busy_no, done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit fin = 1'b0;

  irb_burst_timer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .car_sel_i(car_sel_i),
    .duty_sel_i(duty_sel_i), .load_i(load_i), .load_data_i(load_data_i),
    .rem_o(rem_o), .busy_no(busy_no), .done_o(done_o)
  );

  always #2 clk_i = ~clk_i;

  // reference state from the requirements
  int   m_pre, m_ph, m_cnt;
  bit   m_en, m_live;

  function automatic int wrap_of(input bit sel);
    return sel ? 11 : 7;
  endfunction
  function automatic int high_of(input bit sel, input bit duty);
    if (!sel) return 4;
    return duty ? 4 : 6;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = 0; m_ph = 0; m_cnt = 0; m_en = 0; m_live = 0;
    end else begin
      bit tk;
      tk = (m_pre == 7);
      m_pre = (m_pre + 1) % 8;
      m_ph = (m_ph >= wrap_of(car_sel_i)) ? 0 : m_ph + 1;
      if (load_i) begin
        m_cnt = int'(load_data_i[8:0]); m_en = load_data_i[9]; m_live = 1;
      end else if (run_i && tk && m_live) begin
        if (m_cnt == 0) m_live = 0; else m_cnt = m_cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // advance to the next falling edge and compare outputs with the model
  task automatic step();
    bit g, er;
    @(negedge clk_i);
    g  = m_live && run_i && m_en;
    er = g && (m_ph < high_of(car_sel_i, duty_sel_i));
    chk(rem_o == er, car_sel_i ? "R7 rem" : "R6 rem", int'(rem_o), int'(er));
    chk(busy_no == !g, "R5 busy", int'(busy_no), int'(!g));
    chk(done_o == !m_live, "R3 done", int'(done_o), int'(!m_live));
  endtask

  task automatic load_word(input bit en, input int n);
    load_data_i = {en, 9'(n)};
    load_i = 1'b1;
    step();
    load_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk(rem_o == 1'b0 && busy_no == 1'b1 && done_o == 1'b1, "R1 reset outputs",
        int'({rem_o, busy_no, done_o}), 3);
    rst_ni = 1'b1;
    run_i = 1'b1;
    repeat (5) step();
    chk(done_o == 1'b1 && busy_no == 1'b1, "R1 idle after release",
        int'({busy_no, done_o}), 3);

    // R3: aligned burst N=3 lasts 32 clocks
    while (m_pre != 7) step();
    begin
      int low_cnt;
      load_word(1'b1, 3);
      low_cnt = (busy_no == 1'b0) ? 1 : 0;
      for (int i = 0; i < 2000 && busy_no == 1'b0; i++) begin
        step();
        if (busy_no == 1'b0) low_cnt++;
      end
      chk(low_cnt == 32, "R3 burst length", low_cnt, 32);
      chk(done_o == 1'b1, "R3 done after expiry", int'(done_o), 1);
    end

    // R8: reload on the expiring tick
    load_word(1'b1, 2);
    while (!(m_live && m_cnt == 0 && m_pre == 7)) step();
    load_word(1'b1, 1);
    chk(done_o == 1'b0 && busy_no == 1'b0, "R8 seamless reload",
        int'({busy_no, done_o}), 0);
    while (m_live) step();

    // R2: run low freezes and silences
    load_word(1'b1, 5);
    run_i = 1'b0;
    repeat (40) step();
    chk(busy_no == 1'b1 && done_o == 1'b0 && rem_o == 1'b0, "R2 frozen",
        int'({rem_o, busy_no, done_o}), 2);
    run_i = 1'b1;
    while (m_live) step();

    // R4: enable 0 gives a silent timed gap
    load_word(1'b0, 4);
    repeat (12) step();
    chk(busy_no == 1'b1 && done_o == 1'b0, "R4 silent gap",
        int'({busy_no, done_o}), 2);
    while (m_live) step();

    // R7: both duties at divide 12, R6 at divide 8; R10 carrier unaffected by loads
    car_sel_i = 1'b1; duty_sel_i = 1'b0;
    load_word(1'b1, 8);
    repeat (30) step();
    duty_sel_i = 1'b1;
    repeat (30) step();
    car_sel_i = 1'b0;
    load_word(1'b1, 6); // R9 mid-burst override, R10 phase kept
    while (m_live) step();

    // full-scale count
    load_word(1'b1, 511);
    while (m_live) step();
    chk(done_o == 1'b1, "R3 full-scale expiry", int'(done_o), 1);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      run_i = ($urandom % 10) != 0;
      if (($urandom % 150) == 0) car_sel_i = ~car_sel_i;
      if (($urandom % 150) == 0) duty_sel_i = ~duty_sel_i;
      if (!m_live || ($urandom % 60) == 0)
        load_word(1'($urandom % 4 != 0), int'($urandom % 24));
      else step();
    end

    fin = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule